// File: doc/BRIEF.md
# Broadside Test Sequencer

This block drives a two-pattern (broadside) scan test, or a longer one, on a small circuit with a full or partial scan chain. A start pulse captures three things: the initial state, the number of functional patterns and the index of the single pattern that is to run at speed. The sequencer then moves through its states in a fixed order. In ST_SHIFT_IN it shifts the initial state into the chain with scan enable high. In ST_FUNC_SLOW and ST_FUNC_FAST it applies one primary-input vector per functional clock. In ST_SHIFT_OUT it unloads the final state. ST_DONE then raises a done pulse, and the sequencer returns to ST_IDLE.

The circuit under test is clocked only through the clock-enable output. A slow functional cycle is modelled by a single enable that comes `SLOW_DIV` system cycles after the previous enable. The fast pattern gets its enable on the cycle right after the previous one. The sequencer asks for vectors by index and passes the chosen vector to the circuit. Each functional pattern's primary outputs are returned on a valid strobe, in pattern order. The scanned-out state follows on a second strobe, lowest chain bit first, so that an external comparator can detect faults.

The transitions are as follows:
- ST_IDLE goes to ST_SHIFT_IN when start is seen.
- ST_SHIFT_IN goes to ST_FUNC_FAST or ST_FUNC_SLOW after its last shift. It picks ST_FUNC_FAST when pattern 0 is the fast one.
- A functional state moves on at each of its enables. It goes to ST_FUNC_FAST if the next pattern is the fast one, to ST_FUNC_SLOW if it is not, and to ST_SHIFT_OUT after the last pattern.
- ST_SHIFT_OUT goes to ST_DONE after its last shift.
- ST_DONE goes to ST_IDLE.

Top module: `bst_seq`

## Requirements
- R1: After reset, done_o, scan_en_o, clk_en_o, po_valid_o and so_valid_o are all low, and cut_pi_o is zero.
- R2: After start_i, the block holds scan_en_o and clk_en_o high for exactly CHAIN_LEN cycles. In shift cycle j, scan_si_o carries bit j of the captured initial state, so bit 0 goes first.
- R3: The functional pattern count is captured at start. A value below 2 is raised to 2, and a value above MAX_FUNC is lowered to MAX_FUNC. Exactly that many clock enables are then given with scan_en_o low.
- R4: The fast-pattern index is captured at start. An index greater than the last pattern index is clamped to the last pattern.
- R5: A slow pattern's enable comes exactly SLOW_DIV cycles after the preceding enable. The fast pattern's enable comes exactly one cycle after the preceding enable. The enable that precedes functional pattern 0 is the last shift-in enable.
- R6: During functional pattern k, vec_idx_o equals k and cut_pi_o equals pi_vec_i. Outside the functional states cut_pi_o is zero.
- R7: One cycle after each functional enable, po_valid_o is high for one cycle. po_data_o then carries the cut_po_i value sampled at that enable. These outputs come in pattern order.
- R8: After the last functional pattern, the block holds scan_en_o and clk_en_o high for CHAIN_LEN cycles. One cycle after each of those shifts, so_valid_o is high and so_bit_o holds scan_so_i as sampled at that shift. Every po_valid_o pulse of a test comes before its first so_valid_o pulse.
- R9: done_o is high for exactly one cycle, one cycle after the last shift-out cycle, and the block then returns to idle.
- R10: A start_i pulse while a test is running has no effect. The count, the fast index and the initial state of the running test stay unchanged, and no second test follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted in idle only |
| n_func_i | input | $clog2(MAX_FUNC+1) | Requested number of functional patterns |
| fast_idx_i | input | $clog2(MAX_FUNC) | Index of the at-speed pattern |
| init_state_i | input | CHAIN_LEN | State to shift into the chain |
| done_o | output | 1 | One-cycle end-of-test pulse |
| scan_en_o | output | 1 | Chain shift mode |
| clk_en_o | output | 1 | Clock enable for the circuit under test |
| scan_si_o | output | 1 | Serial scan data into the chain |
| scan_so_i | input | 1 | Serial scan data out of the chain |
| vec_idx_o | output | $clog2(MAX_FUNC) | Index of the vector being requested |
| pi_vec_i | input | PI_W | Vector supplied for vec_idx_o |
| cut_pi_o | output | PI_W | Primary inputs to the circuit |
| cut_po_i | input | PO_W | Primary outputs of the circuit |
| po_valid_o | output | 1 | Strobe for a captured output vector |
| po_data_o | output | PO_W | Captured output vector |
| so_valid_o | output | 1 | Strobe for a scanned-out bit |
| so_bit_o | output | 1 | Scanned-out bit |

## Verification
The main function is tried with several combinations of pattern count and fast index:
- The plain two-pattern test, slow then fast, establishes the baseline timing.
- A longer test with the fast pattern in the middle shows that pacing switches from slow to fast and back again.
- A test whose first pattern is fast shows that the at-speed enable can follow the last shift directly.
- An oversized fast index and pattern counts of 0, 1 and 15 separate clamped configurations from configurations passed through unchanged.
- A second start during a run shows whether the configuration is latched or re-read.

Each run uses a different initial state and vector set. A chain-order or output-order error therefore shows up as wrong data.

// File: rtl/bst_pkg.sv
package bst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT_IN,
        ST_FUNC_SLOW,
        ST_FUNC_FAST,
        ST_SHIFT_OUT,
        ST_DONE
    } seq_state_t;

    function automatic logic is_shift(seq_state_t s);
        return (s == ST_SHIFT_IN) || (s == ST_SHIFT_OUT);
    endfunction

    function automatic logic is_func(seq_state_t s);
        return (s == ST_FUNC_SLOW) || (s == ST_FUNC_FAST);
    endfunction

endpackage

// File: rtl/bst_cfg.sv
module bst_cfg #(
    parameter int MAX_FUNC = 8,
    localparam int NW = $clog2(MAX_FUNC + 1),
    localparam int IW = $clog2(MAX_FUNC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [NW-1:0] n_func_i,
    input  logic [IW-1:0] fast_idx_i,
    output logic [IW-1:0] last_idx_o,
    output logic [IW-1:0] fast_idx_o
);

    logic [NW-1:0] count_c;
    logic [NW-1:0] last_n;
    logic [IW-1:0] last_c;
    logic [IW-1:0] fast_c;

    always_comb begin
        if (n_func_i < NW'(2)) begin
            count_c = NW'(2);
        end else if (n_func_i > NW'(MAX_FUNC)) begin
            count_c = NW'(MAX_FUNC);
        end else begin
            count_c = n_func_i;
        end
        last_n = count_c - NW'(1);
        last_c = IW'(last_n);
        fast_c = (NW'(fast_idx_i) > last_n) ? last_c : fast_idx_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_idx_o <= IW'(1);
            fast_idx_o <= IW'(1);
        end else if (load_i) begin
            last_idx_o <= last_c;
            fast_idx_o <= fast_c;
        end
    end

endmodule

// File: rtl/bst_pace.sv
module bst_pace #(
    parameter int SLOW_DIV = 4,
    localparam int CW = $clog2(SLOW_DIV + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == CW'(SLOW_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_i && !tick_o) begin
            cnt_q <= cnt_q + CW'(1);
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/bst_scan.sv
module bst_scan #(
    parameter int CHAIN_LEN = 6,
    parameter int PO_W      = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [CHAIN_LEN-1:0] init_i,
    input  logic                 shift_i,
    output logic                 si_o,
    input  logic                 so_cap_i,
    input  logic                 so_i,
    output logic                 so_valid_o,
    output logic                 so_bit_o,
    input  logic                 po_cap_i,
    input  logic [PO_W-1:0]      po_i,
    output logic                 po_valid_o,
    output logic [PO_W-1:0]      po_data_o
);

    logic [CHAIN_LEN-1:0] load_q;

    assign si_o = load_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (load_i) begin
            load_q <= init_i;
        end else if (shift_i) begin
            load_q <= {1'b0, load_q[CHAIN_LEN-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so_valid_o <= 1'b0;
            so_bit_o   <= 1'b0;
            po_valid_o <= 1'b0;
            po_data_o  <= '0;
        end else begin
            so_valid_o <= so_cap_i;
            po_valid_o <= po_cap_i;
            if (so_cap_i) begin
                so_bit_o <= so_i;
            end
            if (po_cap_i) begin
                po_data_o <= po_i;
            end
        end
    end

endmodule

// File: rtl/bst_seq.sv
module bst_seq #(
    parameter int CHAIN_LEN = 6,
    parameter int PI_W      = 4,
    parameter int PO_W      = 3,
    parameter int MAX_FUNC  = 8,
    parameter int SLOW_DIV  = 4,
    localparam int NW = $clog2(MAX_FUNC + 1),
    localparam int IW = $clog2(MAX_FUNC),
    localparam int BW = $clog2(CHAIN_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NW-1:0]        n_func_i,
    input  logic [IW-1:0]        fast_idx_i,
    input  logic [CHAIN_LEN-1:0] init_state_i,
    output logic                 done_o,
    output logic                 scan_en_o,
    output logic                 clk_en_o,
    output logic                 scan_si_o,
    input  logic                 scan_so_i,
    output logic [IW-1:0]        vec_idx_o,
    input  logic [PI_W-1:0]      pi_vec_i,
    output logic [PI_W-1:0]      cut_pi_o,
    input  logic [PO_W-1:0]      cut_po_i,
    output logic                 po_valid_o,
    output logic [PO_W-1:0]      po_data_o,
    output logic                 so_valid_o,
    output logic                 so_bit_o
);
    import bst_pkg::*;

    seq_state_t    state_q;
    seq_state_t    state_d;
    logic [BW-1:0] bit_q;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] last_idx;
    logic [IW-1:0] fast_idx;
    logic          accept;
    logic          bit_last;
    logic          slow_tick;
    logic          func_en;
    logic          idx_last;
    logic [IW-1:0] idx_next;

    assign accept   = (state_q == ST_IDLE) && start_i;
    assign bit_last = (bit_q == BW'(CHAIN_LEN - 1));
    assign func_en  = ((state_q == ST_FUNC_SLOW) && slow_tick) || (state_q == ST_FUNC_FAST);
    assign idx_last = (idx_q == last_idx);
    assign idx_next = idx_q + IW'(1);

    bst_cfg #(.MAX_FUNC(MAX_FUNC)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .n_func_i   (n_func_i),
        .fast_idx_i (fast_idx_i),
        .last_idx_o (last_idx),
        .fast_idx_o (fast_idx)
    );

    bst_pace #(.SLOW_DIV(SLOW_DIV)) u_pace (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_FUNC_SLOW),
        .tick_o (slow_tick)
    );

    bst_scan #(.CHAIN_LEN(CHAIN_LEN), .PO_W(PO_W)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .init_i     (init_state_i),
        .shift_i    (state_q == ST_SHIFT_IN),
        .si_o       (scan_si_o),
        .so_cap_i   (state_q == ST_SHIFT_OUT),
        .so_i       (scan_so_i),
        .so_valid_o (so_valid_o),
        .so_bit_o   (so_bit_o),
        .po_cap_i   (func_en),
        .po_i       (cut_po_i),
        .po_valid_o (po_valid_o),
        .po_data_o  (po_data_o)
    );

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (is_shift(state_q) && !bit_last) begin
                bit_q <= bit_q + BW'(1);
            end else begin
                bit_q <= '0;
            end
            if (state_q == ST_IDLE) begin
                idx_q <= '0;
            end else if (func_en) begin
                idx_q <= idx_next;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_SHIFT_IN;
            end
            ST_SHIFT_IN: begin
                if (bit_last) begin
                    state_d = (fast_idx == '0) ? ST_FUNC_FAST : ST_FUNC_SLOW;
                end
            end
            ST_FUNC_SLOW, ST_FUNC_FAST: begin
                if (func_en) begin
                    if (idx_last) begin
                        state_d = ST_SHIFT_OUT;
                    end else begin
                        state_d = (idx_next == fast_idx) ? ST_FUNC_FAST : ST_FUNC_SLOW;
                    end
                end
            end
            ST_SHIFT_OUT: begin
                if (bit_last) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        scan_en_o = is_shift(state_q);
        clk_en_o  = is_shift(state_q) || func_en;
        done_o    = (state_q == ST_DONE);
        vec_idx_o = is_func(state_q) ? idx_q : '0;
        cut_pi_o  = is_func(state_q) ? pi_vec_i : '0;
    end

endmodule

// File: rtl/bst_seq_chk.sv
module bst_seq_chk #(
    parameter int PI_W     = 4,
    parameter int SLOW_DIV = 4
) (
    input logic                clk,
    input logic                rst_n,
    input bst_pkg::seq_state_t state_q,
    input logic                scan_en_o,
    input logic                clk_en_o,
    input logic                po_valid_o,
    input logic                so_valid_o,
    input logic                done_o,
    input logic [PI_W-1:0]     cut_pi_o
);
    import bst_pkg::*;

    logic [7:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (clk_en_o) begin
            gap_q <= '0;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    p_shift_clocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en_o |-> clk_en_o);

    p_slow_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FUNC_SLOW && clk_en_o) |-> (gap_q == 8'(SLOW_DIV - 1)));

    p_fast_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FUNC_FAST) |-> $past(clk_en_o));

    p_pi_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en_o |-> (cut_pi_o == '0));

    p_po_after_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        po_valid_o |-> $past(clk_en_o && !scan_en_o));

    p_so_after_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        so_valid_o |-> $past(scan_en_o));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && state_q == ST_IDLE));

endmodule

bind bst_seq bst_seq_chk #(.PI_W(PI_W), .SLOW_DIV(SLOW_DIV)) u_bst_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .scan_en_o  (scan_en_o),
    .clk_en_o   (clk_en_o),
    .po_valid_o (po_valid_o),
    .so_valid_o (so_valid_o),
    .done_o     (done_o),
    .cut_pi_o   (cut_pi_o)
);

// File: tb/test_bst_seq.sv
module test_bst_seq;
    localparam int L    = 6;
    localparam int PIW  = 4;
    localparam int POW  = 3;
    localparam int MAXF = 8;
    localparam int SDIV = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [3:0]     n_func = '0;
    logic [2:0]     fast_idx = '0;
    logic [L-1:0]   init_state = '0;
    logic           done, scan_en, clk_en, scan_si, scan_so;
    logic [2:0]     vec_idx;
    logic [PIW-1:0] pi_vec, cut_pi;
    logic [POW-1:0] cut_po, po_data;
    logic           po_valid, so_valid, so_bit;

    logic [PIW-1:0] vecs [MAXF];
    logic [L-1:0]   chain = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    bst_seq i_bst_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .n_func_i(n_func),
        .fast_idx_i(fast_idx), .init_state_i(init_state), .done_o(done),
        .scan_en_o(scan_en), .clk_en_o(clk_en), .scan_si_o(scan_si),
        .scan_so_i(scan_so), .vec_idx_o(vec_idx), .pi_vec_i(pi_vec),
        .cut_pi_o(cut_pi), .cut_po_i(cut_po), .po_valid_o(po_valid),
        .po_data_o(po_data), .so_valid_o(so_valid), .so_bit_o(so_bit)
    );

    // Circuit under test model
    function automatic logic [L-1:0] nxt_fn(logic [L-1:0] s, logic [PIW-1:0] p);
        return {s[L-2:0], s[L-1]} ^ {2'b00, p};
    endfunction

    function automatic logic [POW-1:0] po_fn(logic [L-1:0] s, logic [PIW-1:0] p);
        return s[2:0] ^ s[5:3] ^ p[2:0];
    endfunction

    assign pi_vec  = vecs[vec_idx];
    assign scan_so = chain[0];
    assign cut_po  = po_fn(chain, cut_pi);

    always @(posedge clk) begin
        if (clk_en) begin
            if (scan_en) chain <= {scan_si, chain[L-1:1]};
            else         chain <= nxt_fn(chain, cut_pi);
        end
    end

    // Monitor, sampled at the falling edge
    int       n_en, n_sh, n_fe, n_po, n_so, n_done, pi_bad;
    int       en_cyc [64];
    logic     si_rec [L];
    logic [POW-1:0] po_rec [MAXF];
    logic     so_rec [L];
    int       last_po_cyc, first_so_cyc;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (clk_en && n_en < 64) begin
            en_cyc[n_en] = cyc;
            n_en = n_en + 1;
        end
        if (scan_en && clk_en) begin
            if (n_sh < L) si_rec[n_sh] = scan_si;
            n_sh = n_sh + 1;
        end
        if (clk_en && !scan_en) begin
            if (int'(vec_idx) != n_fe || cut_pi != vecs[n_fe % MAXF]) pi_bad = pi_bad + 1;
            n_fe = n_fe + 1;
        end
        if (po_valid) begin
            if (n_po < MAXF) po_rec[n_po] = po_data;
            n_po = n_po + 1;
            last_po_cyc = cyc;
        end
        if (so_valid) begin
            if (n_so < L) so_rec[n_so] = so_bit;
            if (n_so == 0) first_so_cyc = cyc;
            n_so = n_so + 1;
        end
        if (done) n_done = n_done + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_en = 0; n_sh = 0; n_fe = 0; n_po = 0; n_so = 0; n_done = 0; pi_bad = 0;
        last_po_cyc = 0; first_so_cyc = 0;
    endtask

    // One full test, optional second start while busy (R10)
    task automatic run_test(input logic [L-1:0] init, input int n, input int f,
                            input int seed, input bit poke);
        int nf, fe, wd;
        logic [L-1:0] st;
        logic [POW-1:0] po_exp [MAXF];
        nf = (n < 2) ? 2 : ((n > MAXF) ? MAXF : n);
        fe = (f > nf - 1) ? nf - 1 : f;
        for (int k = 0; k < MAXF; k++) vecs[k] = PIW'(seed + 5 * k + (k >> 1));
        st = init;
        for (int k = 0; k < nf; k++) begin
            po_exp[k] = po_fn(st, vecs[k]);
            st = nxt_fn(st, vecs[k]);
        end
        @(negedge clk); #1;
        clear_mon();
        n_func = 4'(n); fast_idx = 3'(f); init_state = init; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        if (poke) begin
            wd = 0;
            while (n_fe < 1 && wd < 500) begin @(negedge clk); wd++; end
            #1;
            n_func = 4'd6; fast_idx = 3'd0; init_state = ~init; start = 1'b1;
            @(negedge clk); #1;
            start = 1'b0;
        end
        wd = 0;
        while (n_done < 1 && wd < 2000) begin @(negedge clk); wd++; end
        check(wd < 2000, "R9 done reached", wd, 0);
        repeat (60) @(negedge clk);
        #1;
        check(n_done == 1, "R9/R10 done pulse count", n_done, 1);
        check(n_sh == 2 * L, "R2/R8 shift cycle count", n_sh, 2 * L);
        for (int j = 0; j < L; j++)
            check(si_rec[j] == init[j], "R2 scan-in bit order", si_rec[j], init[j]);
        check(n_fe == nf, "R3 functional pattern count", n_fe, nf);
        if (n_en >= L + nf) begin
            for (int k = 0; k < nf; k++)
                check(en_cyc[L + k] - en_cyc[L + k - 1] == ((k == fe) ? 1 : SDIV),
                      (k == fe) ? "R4/R5 fast gap" : "R5 slow gap",
                      en_cyc[L + k] - en_cyc[L + k - 1], (k == fe) ? 1 : SDIV);
        end
        check(pi_bad == 0, "R6 vector index and PI pass-through", pi_bad, 0);
        check(n_po == nf, "R7 output strobe count", n_po, nf);
        for (int k = 0; k < nf && k < n_po; k++)
            check(po_rec[k] == po_exp[k], "R7 output vector", po_rec[k], po_exp[k]);
        check(n_so == L, "R8 scan-out strobe count", n_so, L);
        for (int j = 0; j < L; j++)
            check(so_rec[j] == st[j], "R8 scanned-out state", so_rec[j], st[j]);
        check(first_so_cyc > last_po_cyc, "R8 outputs before scan-out", first_so_cyc, last_po_cyc + 1);
        check(!scan_en && !clk_en && !done, "R9 idle after done", scan_en, 0);
    endtask

    task automatic t_reset();
        check(!done && !scan_en && !clk_en, "R1 reset controls", {done, scan_en, clk_en}, 0);
        check(!po_valid && !so_valid, "R1 reset strobes", {po_valid, so_valid}, 0);
        check(cut_pi == '0, "R1 reset PI", cut_pi, 0);
    endtask

    task automatic t_basic();      run_test(6'b101101, 2, 1, 3, 1'b0);  endtask
    task automatic t_mid_fast();   run_test(6'b010011, 4, 2, 7, 1'b0);  endtask
    task automatic t_fast_first(); run_test(6'b111000, 5, 0, 11, 1'b0); endtask
    task automatic t_clamp_fast(); run_test(6'b100110, 3, 7, 2, 1'b0);  endtask
    task automatic t_low_count();  run_test(6'b011110, 0, 1, 9, 1'b0);
                                   run_test(6'b000101, 1, 0, 4, 1'b0);  endtask
    task automatic t_high_count(); run_test(6'b110011, 15, 5, 6, 1'b0); endtask
    task automatic t_busy_start(); run_test(6'b001011, 3, 1, 13, 1'b1); endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < MAXF; k++) vecs[k] = '0;
        clear_mon();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        t_reset();
        t_basic();
        t_mid_fast();
        t_fast_first();
        t_clamp_fast();
        t_low_count();
        t_high_count();
        t_busy_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule